// File: doc/BRIEF.md
# Host Command Packet Router

This block sits between the host-link packet FIFOs and a memory access engine. On its receive side it looks at the 512-bit command packet at the head of the host input FIFO and decodes the opcode in the most significant byte. A memory row read/write command is passed on to the memory engine's command FIFO. Any other opcode is removed from the input FIFO and thrown away, and a saturating error counter records the event.

On its transmit side it takes each 256-bit word that the memory engine returns, puts a fixed header and zero padding around it, and writes the resulting 512-bit packet into the host output FIFO.

Both FIFO interfaces are first-word-fall-through: the head word is visible whenever the FIFO is not empty, and a pop in a cycle removes it at the next edge. The receive and transmit paths have no state of their own. Each decision is made in the same cycle the FIFO flags are presented, so one packet can move per cycle in each direction.

Top module: `host_pkt_router`

## Requirements
- R1: When the input FIFO is not empty, the opcode in bits [511:504] equals 0x02 and the memory command FIFO is not full, the block pushes to the memory command FIFO and pops the input FIFO in the same cycle. The pushed word is packet bits [279:0]: bit 279 is the direction (1 = write, 0 = read), bits [278:256] are the 23-bit row address and bits [255:0] are the payload.
- R2: When a 0x02 command is at the head and the memory command FIFO is full, the block neither pops the input FIFO nor pushes a command. The command stays at the head.
- R3: When the input FIFO is not empty and the opcode is not 0x02, the block pops the input FIFO and does not push a memory command, whatever the memory FIFO's full flag is.
- R4: Each discarded packet raises the 8-bit error count by one. At 255 the count holds.
- R5: When the memory response FIFO is not empty and the host output FIFO is not full, the block pushes one host packet and pops the response FIFO in the same cycle. The packet is 0xBBBB in bits [511:496], zeros in bits [495:256] and the response word in bits [255:0].
- R6: When the host output FIFO is full, the block neither pushes a host packet nor pops the response FIFO.
- R7: When the input FIFO is empty, the block does not pop it or push a memory command, and the error count does not change.
- R8: Asynchronous reset clears the error count to zero at once.
- R9: The receive and transmit paths act independently, and both may transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_in_data_i | input | 512 | Head packet of the host input FIFO |
| cmd_in_empty_i | input | 1 | Host input FIFO empty |
| cmd_in_pop_o | output | 1 | Pop the host input FIFO |
| mem_cmd_data_o | output | 280 | Direction, row address and payload toward the memory engine |
| mem_cmd_full_i | input | 1 | Memory command FIFO full |
| mem_cmd_push_o | output | 1 | Push into the memory command FIFO |
| rsp_data_i | input | 256 | Head word of the memory response FIFO |
| rsp_empty_i | input | 1 | Memory response FIFO empty |
| rsp_pop_o | output | 1 | Pop the memory response FIFO |
| host_data_o | output | 512 | Response packet toward the host |
| host_full_i | input | 1 | Host output FIFO full |
| host_push_o | output | 1 | Push into the host output FIFO |
| err_count_o | output | 8 | Saturating count of discarded packets |

## Verification
The bound checker checks the following on every cycle:
- the handshake rules between each FIFO flag and the matching push and pop: forwarding only into a free FIFO, holding on full, dropping unknown opcodes, and staying idle on empty;
- the response header;
- the count's step-or-hold behaviour.

Some things only the bench's scenarios can show:
- that the forwarded fields and the response payload carry exactly the right bits;
- that the count reaches 255 after a long run of bad opcodes and stays there;
- that an asynchronous reset in the middle of a cycle clears the count without waiting for an edge.

// File: rtl/host_pkt_router_pkg.sv
package host_pkt_router_pkg;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned HDR_W  = 16;
  localparam logic [OP_W-1:0]  OPC_MEM_RW = 8'h02;
  localparam logic [HDR_W-1:0] RSP_HDR    = 16'hBBBB;

  typedef enum logic [1:0] {
    RX_NONE = 2'd0,
    RX_FWD  = 2'd1,
    RX_HOLD = 2'd2,
    RX_DROP = 2'd3
  } rx_action_e;
endpackage

// File: rtl/hpr_rx_decode.sv
module hpr_rx_decode
  import host_pkt_router_pkg::*;
#(
  parameter int unsigned PKT_W  = 512,
  parameter int unsigned CMD_W  = 280
) (
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             empty_i,
  input  logic             dst_full_i,
  output logic             pop_o,
  output logic             push_o,
  output logic             drop_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic [OP_W-1:0] opcode;
  rx_action_e      act;
  logic            unused_pad;

  assign opcode     = pkt_i[PKT_W-1 -: OP_W];
  assign cmd_o      = pkt_i[CMD_W-1:0];
  assign unused_pad = ^pkt_i[PKT_W-OP_W-1:CMD_W];

  always_comb begin
    if (empty_i)                  act = RX_NONE;
    else if (opcode != OPC_MEM_RW) act = RX_DROP;
    else if (dst_full_i)          act = RX_HOLD;
    else                          act = RX_FWD;
  end

  assign push_o = (act == RX_FWD);
  assign drop_o = (act == RX_DROP);
  assign pop_o  = push_o | drop_o;
endmodule

// File: rtl/hpr_tx_wrap.sv
module hpr_tx_wrap
  import host_pkt_router_pkg::*;
#(
  parameter int unsigned PKT_W  = 512,
  parameter int unsigned DATA_W = 256
) (
  input  logic [DATA_W-1:0] rsp_i,
  input  logic              empty_i,
  input  logic              dst_full_i,
  output logic              pop_o,
  output logic              push_o,
  output logic [PKT_W-1:0]  pkt_o
);
  localparam int unsigned PAD_W = PKT_W - HDR_W - DATA_W;

  assign push_o = ~empty_i & ~dst_full_i;
  assign pop_o  = push_o;
  assign pkt_o  = {RSP_HDR, {PAD_W{1'b0}}, rsp_i};
endmodule

// File: rtl/hpr_sat_counter.sv
module hpr_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/host_pkt_router.sv
module host_pkt_router
  import host_pkt_router_pkg::*;
#(
  parameter int unsigned PKT_W  = 512,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned ERR_W  = 8,
  localparam int unsigned CMD_W = DATA_W + ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PKT_W-1:0]  cmd_in_data_i,
  input  logic              cmd_in_empty_i,
  output logic              cmd_in_pop_o,
  output logic [CMD_W-1:0]  mem_cmd_data_o,
  input  logic              mem_cmd_full_i,
  output logic              mem_cmd_push_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              rsp_empty_i,
  output logic              rsp_pop_o,
  output logic [PKT_W-1:0]  host_data_o,
  input  logic              host_full_i,
  output logic              host_push_o,
  output logic [ERR_W-1:0]  err_count_o
);
  logic drop;

  hpr_rx_decode #(.PKT_W(PKT_W), .CMD_W(CMD_W)) u_rx (
    .pkt_i      (cmd_in_data_i),
    .empty_i    (cmd_in_empty_i),
    .dst_full_i (mem_cmd_full_i),
    .pop_o      (cmd_in_pop_o),
    .push_o     (mem_cmd_push_o),
    .drop_o     (drop),
    .cmd_o      (mem_cmd_data_o)
  );

  hpr_tx_wrap #(.PKT_W(PKT_W), .DATA_W(DATA_W)) u_tx (
    .rsp_i      (rsp_data_i),
    .empty_i    (rsp_empty_i),
    .dst_full_i (host_full_i),
    .pop_o      (rsp_pop_o),
    .push_o     (host_push_o),
    .pkt_o      (host_data_o)
  );

  hpr_sat_counter #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (err_count_o)
  );
endmodule

// File: rtl/host_pkt_router_chk.sv
module host_pkt_router_chk
  import host_pkt_router_pkg::*;
#(
  parameter int unsigned PKT_W  = 512,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned ERR_W  = 8,
  localparam int unsigned CMD_W = DATA_W + ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PKT_W-1:0]  cmd_in_data_i,
  input logic              cmd_in_empty_i,
  input logic              cmd_in_pop_o,
  input logic [CMD_W-1:0]  mem_cmd_data_o,
  input logic              mem_cmd_full_i,
  input logic              mem_cmd_push_o,
  input logic [DATA_W-1:0] rsp_data_i,
  input logic              rsp_empty_i,
  input logic              rsp_pop_o,
  input logic [PKT_W-1:0]  host_data_o,
  input logic              host_full_i,
  input logic              host_push_o,
  input logic [ERR_W-1:0]  err_count_o
);
  logic is_rw;
  assign is_rw = (cmd_in_data_i[PKT_W-1 -: OP_W] == OPC_MEM_RW);

  p_fwd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_push_o |-> cmd_in_pop_o && !mem_cmd_full_i && !cmd_in_empty_i && is_rw);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_in_empty_i && is_rw && mem_cmd_full_i) |-> !cmd_in_pop_o && !mem_cmd_push_o);

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_in_empty_i && !is_rw) |-> cmd_in_pop_o && !mem_cmd_push_o);

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_in_pop_o && !mem_cmd_push_o) |=>
      err_count_o == (($past(err_count_o) == {ERR_W{1'b1}}) ? $past(err_count_o)
                                                            : $past(err_count_o) + 1'b1));

  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_in_pop_o && !mem_cmd_push_o) |=> $stable(err_count_o));

  p_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_push_o |-> rsp_pop_o && !rsp_empty_i && host_data_o[PKT_W-1 -: HDR_W] == RSP_HDR);

  p_rsp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_full_i |-> !host_push_o && !rsp_pop_o);

  p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_in_empty_i |-> !cmd_in_pop_o && !mem_cmd_push_o);
endmodule

bind host_pkt_router host_pkt_router_chk #(
  .PKT_W(PKT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W)
) u_chk (.*);

// File: tb/host_pkt_router_test.sv
module host_pkt_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // {opcode, in_empty, mem_full, rsp_empty, host_full, exp cmd_pop, mem_push, rsp_pop, host_push, exp err_inc}
  localparam logic [16:0] VEC [NV] = '{
    {8'h02, 4'b0010, 4'b1100, 1'b0},  // R1 forward
    {8'h02, 4'b0110, 4'b0000, 1'b0},  // R2 hold on full
    {8'h07, 4'b0010, 4'b1000, 1'b1},  // R3 drop
    {8'h07, 4'b0110, 4'b1000, 1'b1},  // R3 drop while full
    {8'h02, 4'b1010, 4'b0000, 1'b0},  // R7 empty
    {8'h00, 4'b0000, 4'b1011, 1'b1},  // R3 + R5
    {8'h02, 4'b0001, 4'b1100, 1'b0},  // R6 host full
    {8'hFF, 4'b1000, 4'b0011, 1'b0},  // R7 + R5
    {8'h02, 4'b0100, 4'b0011, 1'b0},  // R2 + R5
    {8'h03, 4'b0001, 4'b1000, 1'b1},  // R3 + R6
    {8'h82, 4'b0010, 4'b1000, 1'b1},  // R3 near-miss opcode
    {8'h02, 4'b0000, 4'b1111, 1'b0}   // R9 both paths
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [511:0] cmd_in_data_i = '0;
  logic         cmd_in_empty_i = 1'b1;
  logic         cmd_in_pop_o;
  logic [279:0] mem_cmd_data_o;
  logic         mem_cmd_full_i = 1'b0;
  logic         mem_cmd_push_o;
  logic [255:0] rsp_data_i = '0;
  logic         rsp_empty_i = 1'b1;
  logic         rsp_pop_o;
  logic [511:0] host_data_o;
  logic         host_full_i = 1'b0;
  logic         host_push_o;
  logic [7:0]   err_count_o;

  int n_chk = 0;
  int n_bad = 0;
  int err_model = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_pkt_router uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_in_data_i(cmd_in_data_i), .cmd_in_empty_i(cmd_in_empty_i), .cmd_in_pop_o(cmd_in_pop_o),
    .mem_cmd_data_o(mem_cmd_data_o), .mem_cmd_full_i(mem_cmd_full_i), .mem_cmd_push_o(mem_cmd_push_o),
    .rsp_data_i(rsp_data_i), .rsp_empty_i(rsp_empty_i), .rsp_pop_o(rsp_pop_o),
    .host_data_o(host_data_o), .host_full_i(host_full_i), .host_push_o(host_push_o),
    .err_count_o(err_count_o)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    #(CLK_PERIOD*2 + 1);
    chk("R8 err_count in reset", 512'(err_count_o), 512'd0);
    chk("R7 no pop idle", 512'(cmd_in_pop_o), 512'd0);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [511:0] pkt;
      logic [255:0] rsp;
      logic [16:0]  v;
      v = VEC[i];
      pkt = '0;
      pkt[511:504] = v[16:9];
      pkt[503:280] = {7{32'hDEAD0000 + i}};
      pkt[279]     = i[0];
      pkt[278:256] = 23'(i * 32'h1357 + 5);
      pkt[255:0]   = {8{32'hA5000000 + i}};
      rsp          = {8{32'h0BAD0000 ^ i}};
      @(negedge clk);
      cmd_in_data_i  = pkt;
      cmd_in_empty_i = v[8];
      mem_cmd_full_i = v[7];
      rsp_data_i     = rsp;
      rsp_empty_i    = v[6];
      host_full_i    = v[5];
      #1;
      chk("R1/R2/R3/R7 cmd_in_pop", 512'(cmd_in_pop_o), 512'(v[4]));
      chk("R1/R2/R3/R7 mem_cmd_push", 512'(mem_cmd_push_o), 512'(v[3]));
      chk("R5/R6/R9 rsp_pop", 512'(rsp_pop_o), 512'(v[2]));
      chk("R5/R6/R9 host_push", 512'(host_push_o), 512'(v[1]));
      if (v[3]) chk("R1 forwarded fields", 512'(mem_cmd_data_o), 512'(pkt[279:0]));
      if (v[1]) chk("R5 response packet", host_data_o, {16'hBBBB, 240'd0, rsp});
      if (v[0] && err_model < 255) err_model++;
      @(posedge clk); #1;
      chk("R4/R7 err_count", 512'(err_count_o), 512'(err_model));
    end

    // R4: saturation under a long run of bad opcodes
    @(negedge clk);
    cmd_in_data_i[511:504] = 8'h55;
    cmd_in_empty_i = 1'b0;
    rsp_empty_i = 1'b1;
    for (int k = 0; k < 260; k++) begin
      @(posedge clk);
      if (err_model < 255) err_model++;
    end
    #1;
    chk("R4 saturated at 255", 512'(err_count_o), 512'd255);
    chk("R4 model agrees", 512'(err_model), 512'd255);
    @(posedge clk); #1;
    chk("R4 holds at 255", 512'(err_count_o), 512'd255);

    // R7: empty input leaves count alone
    @(negedge clk) cmd_in_empty_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 count unchanged on empty", 512'(err_count_o), 512'd255);

    // R8: asynchronous reset mid-cycle
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    chk("R8 async clear", 512'(err_count_o), 512'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule